// File: doc/BRIEF.md
# Sequential Cache-Line Stream Prefetcher

This block watches the demand access addresses that a cache presents. It decides when software is walking memory one cache line at a time. It keeps the line address of the last demand access. When the next access lands on the line directly above that stored line, it requests a line three positions beyond the stored one. When the next access lands on the line directly below, it requests the line three positions below. Requests of both kinds are tagged as second-level cache fills. They never target the first-level data cache.

The block only forms request addresses. It holds one pending request behind a valid/ready port until the consumer takes it. A newer trigger overwrites a request that is still waiting. A mode input limits detection to rising streams. Three kinds of event start nothing: an access that repeats the stored line, an access that jumps more than one line, and an access whose target would fall off either end of the address space. A trigger that names the same line as the last request loaded is dropped.

Top module: `stream_prefetcher`

## Requirements
- R1: Line address is the byte address with its low 6 bits removed, so every byte offset within a 64-byte line maps to the same line.
- R2: With line L stored, an access to line L+1 makes `pf_valid` high on the clock edge that takes the access, with `pf_line` = L+3.
- R3: With `asc_only` = 0 and line L stored, an access to line L-1 produces a request for line L-3 with the same timing.
- R4: An access whose line differs from the stored line by two or more produces no request.
- R5: With `asc_only` = 1, a descending adjacent pair produces no request, and ascending pairs still do.
- R6: `pf_l2` is 1 whenever `pf_valid` is 1. The value 1 marks the request as a second-level cache fill.
- R7: After reset `pf_valid` is 0, no line is stored, and the first access after reset never produces a request.
- R8: An access to the stored line produces no request and leaves the stored line unchanged.
- R9: No request is made when L+3 exceeds the highest line or L-3 is below line 0.
- R10: A request stays valid with a stable line until `pf_ready` is seen high. It drops on that edge unless a new trigger arrives. A new trigger replaces a waiting request.
- R11: A trigger whose target equals the last target loaded since reset is suppressed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Demand access present |
| acc_addr | input | ADDR_W | Demand byte address |
| asc_only | input | 1 | 1: detect rising streams only |
| pf_valid | output | 1 | Prefetch request pending |
| pf_ready | input | 1 | Consumer takes the request |
| pf_line | output | ADDR_W-6 | Line address to prefetch |
| pf_l2 | output | 1 | Fill-level tag, 1 = second-level cache |

## Verification
On every cycle, assertions check four things: a waiting request holds its line until it is taken, a taken request clears, a repeated line leaves the stored line untouched, and rising-only mode never yields a descending trigger. Target arithmetic, wrap suppression, duplicate removal and the first-access rule can only be shown by the bench's scenarios. The bench sweeps every ordered pair of lines in a 64-line space in both modes and compares the results against arithmetic expectations.

// File: rtl/sp_pkg.sv
package sp_pkg;
    localparam int LINE_BYTES_LOG2 = 6;
    localparam int LOOKAHEAD       = 3;

    typedef enum logic [1:0] {
        DIR_NONE = 2'd0,
        DIR_UP   = 2'd1,
        DIR_DOWN = 2'd2
    } dir_e;

    typedef struct packed {
        logic hit;
        dir_e dir;
    } match_t;

    function automatic match_t pick_dir(input logic up_ok, input logic dn_ok);
        match_t m;
        m.hit = up_ok | dn_ok;
        m.dir = up_ok ? DIR_UP : (dn_ok ? DIR_DOWN : DIR_NONE);
        return m;
    endfunction
endpackage

// File: rtl/sp_detect.sv
module sp_detect #(
    parameter int LW   = 26,
    parameter int DIST = sp_pkg::LOOKAHEAD
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          acc_valid,
    input  logic [LW-1:0] acc_line,
    input  logic          asc_only,
    output logic          trig,
    output logic [LW-1:0] tgt
);
    import sp_pkg::*;
    localparam logic [LW-1:0] MAXL = {LW{1'b1}};
    localparam logic [LW-1:0] DSTV = LW'(DIST);

    logic [LW-1:0] prev_line;
    logic          prev_vld;
    logic          same, up_ok, dn_ok;
    match_t        m;

    always_comb begin
        same  = prev_vld && (acc_line == prev_line);
        up_ok = acc_valid && prev_vld && (acc_line == prev_line + 1'b1)
                && (prev_line <= MAXL - DSTV);
        dn_ok = acc_valid && prev_vld && !asc_only && (acc_line == prev_line - 1'b1)
                && (prev_line >= DSTV);
        m     = pick_dir(up_ok, dn_ok);
        trig  = m.hit;
        tgt   = (m.dir == DIR_UP) ? prev_line + DSTV : prev_line - DSTV;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_vld  <= 1'b0;
            prev_line <= '0;
        end else if (acc_valid && !same) begin
            prev_vld  <= 1'b1;
            prev_line <= acc_line;
        end
    end

    assert_keep_line_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && prev_vld && acc_line == prev_line) |=> $stable(prev_line));
    assert_rise_only_R5: assert property (@(posedge clk) disable iff (rst)
        (asc_only && trig) |-> (tgt > prev_line));
endmodule

// File: rtl/sp_out.sv
module sp_out #(
    parameter int LW = 26
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          trig,
    input  logic [LW-1:0] tgt,
    input  logic          pf_ready,
    output logic          pf_valid,
    output logic [LW-1:0] pf_line
);
    logic [LW-1:0] last_tgt;
    logic          last_vld;
    logic          load;

    assign load = trig && !(last_vld && last_tgt == tgt);

    always_ff @(posedge clk) begin
        if (rst) begin
            pf_valid <= 1'b0;
            pf_line  <= '0;
            last_vld <= 1'b0;
            last_tgt <= '0;
        end else if (load) begin
            pf_valid <= 1'b1;
            pf_line  <= tgt;
            last_vld <= 1'b1;
            last_tgt <= tgt;
        end else if (pf_valid && pf_ready) begin
            pf_valid <= 1'b0;
        end
    end

    assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && !trig) |=> (pf_valid && $stable(pf_line)));
    assert_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && pf_ready && !trig) |=> !pf_valid);
endmodule

// File: rtl/stream_prefetcher.sv
module stream_prefetcher #(
    parameter int ADDR_W   = 32,
    parameter int LINE_OFF = sp_pkg::LINE_BYTES_LOG2,
    parameter int DIST     = sp_pkg::LOOKAHEAD
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   acc_valid,
    input  logic [ADDR_W-1:0]      acc_addr,
    input  logic                   asc_only,
    output logic                   pf_valid,
    input  logic                   pf_ready,
    output logic [ADDR_W-LINE_OFF-1:0] pf_line,
    output logic                   pf_l2
);
    localparam int LW = ADDR_W - LINE_OFF;

    logic [LW-1:0] acc_line;
    logic          trig;
    logic [LW-1:0] tgt;

    assign acc_line = acc_addr[ADDR_W-1:LINE_OFF];

    sp_detect #(.LW(LW), .DIST(DIST)) det_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_line(acc_line),
        .asc_only(asc_only), .trig(trig), .tgt(tgt)
    );

    sp_out #(.LW(LW)) out_i (
        .clk(clk), .rst(rst), .trig(trig), .tgt(tgt), .pf_ready(pf_ready),
        .pf_valid(pf_valid), .pf_line(pf_line)
    );

    assign pf_l2 = pf_valid;
endmodule

// File: tb/stream_prefetcher_tb.sv
module stream_prefetcher_tb_top;
    localparam int ADDR_W = 12;
    localparam int LW     = 6;

    logic clk = 0, rst = 1, acc_valid = 0, asc_only = 0, pf_ready = 0;
    logic [ADDR_W-1:0] acc_addr = '0;
    logic pf_valid, pf_l2;
    logic [LW-1:0] pf_line;
    int checks = 0, errors = 0;

    always #5 clk = ~clk;

    stream_prefetcher #(.ADDR_W(ADDR_W)) dut_i (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .asc_only(asc_only), .pf_valid(pf_valid), .pf_ready(pf_ready),
        .pf_line(pf_line), .pf_l2(pf_l2)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1; acc_valid = 0; pf_ready = 0;
        @(negedge clk); rst = 0;
    endtask

    task automatic access(input int line, input int off);
        acc_valid = 1; acc_addr = ADDR_W'((line << 6) | (off & 63));
        @(negedge clk); acc_valid = 0;
    endtask

    task automatic expect_req(input string req, input bit v, input int line);
        chk(req, int'(pf_valid), int'(v));
        if (v) begin
            chk(req, int'(pf_line), line);
            chk("R6", int'(pf_l2), 1);
        end
    endtask

    initial begin
        #2000000;
        errors++; checks++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        chk("R7", int'(pf_valid), 0);
        // R2 R3 R4 R5 R9 R7 R1: sweep all line pairs in both modes
        for (int md = 0; md < 2; md++) begin
            for (int a = 0; a < 64; a++) begin
                for (int b = 0; b < 64; b++) begin
                    bit up, dn;
                    do_reset();
                    asc_only = md[0];
                    access(a, a * 7 + b);
                    chk("R7", int'(pf_valid), 0);
                    access(b, b * 13 + 5);
                    up = (b == a + 1) && (a + 3 <= 63);
                    dn = (b == a - 1) && (a - 3 >= 0) && (md == 0);
                    if (up)      expect_req("R2", 1, a + 3);
                    else if (dn) expect_req("R3", 1, a - 3);
                    else if (md == 1 && b == a - 1) expect_req("R5", 0, 0);
                    else if (b == a + 1 || b == a - 1) expect_req("R9", 0, 0);
                    else         expect_req("R4", 0, 0);
                end
            end
        end
        asc_only = 0;
        // R8: repeat keeps stored line
        do_reset();
        access(10, 0); access(10, 63);
        expect_req("R8", 0, 0);
        access(11, 1);
        expect_req("R8", 1, 13);
        // R1: offsets within one line are the same line
        do_reset();
        access(20, 0); access(20, 40);
        expect_req("R1", 0, 0);
        // R10: hold, replace, drain
        do_reset();
        access(10, 0); access(11, 0);
        @(negedge clk);
        expect_req("R10", 1, 13);
        access(30, 0); access(31, 0);
        expect_req("R10", 1, 33);
        pf_ready = 1; @(negedge clk); pf_ready = 0;
        expect_req("R10", 0, 0);
        // R11: duplicate target suppressed
        access(5, 0); access(30, 0); access(31, 0);
        expect_req("R11", 0, 0);
        access(32, 0);
        expect_req("R11", 1, 34);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule